// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is an eight-stage register (the stage count is a parameter) with four operations. It can keep its contents, move them one place toward the high end, move them one place toward the low end, or capture a whole word in one edge. A two-bit mode select picks the operation on each rising clock edge. One bidirectional parallel port carries both the word that is loaded and the word that is read out. The port is modelled as three signals: `pad_in` is what the pins carry, `pad_out` is what the block would drive, and `pad_oe` is the drive enable for a pad cell outside the block.

Each end stage has its own serial input. Both end stages also appear on serial taps that are always driven, so several blocks can be chained even while their ports are off the bus. The two active-low enables only gate the port driver. They never change what the register does. Parallel-load mode switches the driver off on its own, so the register captures the value the outside world puts on the pins. Reset is active-low, synchronous, and beats every other input.

Top module: `univ_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising edge, every stage becomes 0, whatever the mode, serial inputs and port value.
- R2: With mode {`sel_b1`,`sel_b0`} = 00, every stage keeps its value across the edge.
- R3: With mode 01, `ser_in_lo` enters stage 0 and stage i moves to stage i+1; the old top stage is dropped.
- R4: With mode 10, `ser_in_hi` enters stage WIDTH-1 and stage i+1 moves to stage i; the old stage 0 is dropped.
- R5: With mode 11, all stages take the value on `pad_in` at the edge.
- R6: Whenever the mode is 11, `pad_oe` is 0, whatever the enables and whether or not reset is active.
- R7: Whenever `oe_a_n` or `oe_b_n` is 1, `pad_oe` is 0.
- R8: When both enables are 0 and the mode is not 11, `pad_oe` is 1 in the same cycle (no clock delay). `pad_out` always carries the stage contents, with stage i on bit i.
- R9: `tap_lo` always equals stage 0 and `tap_hi` always equals stage WIDTH-1, whatever the enable state.
- R10: The enables have no effect on holding, shifting, loading or clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| sel_b1 | input | 1 | Mode select, high bit |
| sel_b0 | input | 1 | Mode select, low bit |
| oe_a_n | input | 1 | Port enable A, active low |
| oe_b_n | input | 1 | Port enable B, active low |
| ser_in_lo | input | 1 | Serial bit entering stage 0 on an upward shift |
| ser_in_hi | input | 1 | Serial bit entering the top stage on a downward shift |
| pad_in | input | WIDTH | Value present on the port pins |
| pad_out | output | WIDTH | Value offered to the port driver (stage contents) |
| pad_oe | output | 1 | Port driver enable |
| tap_lo | output | 1 | Stage 0, always driven |
| tap_hi | output | 1 | Top stage, always driven |

## Verification
The bench sweeps every combination of mode, both enables and both serial bits against several data words, and keeps an arithmetic model of the stages. Reset is applied while load mode is selected. A design that let reset drive the port would show `pad_oe` high there, and one that let load win over reset would keep the port word instead of zero. Shifts are driven with the enables off, and the state is read back through the always-live taps and `pad_out`. A design that gated shifting or the taps with the enables would then fall out of step with the model. The end bits are checked after each shift direction, so a swapped serial input or a reversed shift shows up as a wrong stage 0 or top stage.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'b00,
        MODE_UP    = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_port_ctrl.sv
module usr_port_ctrl
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  usr_mode_e mode,
    input  logic      oe_a_n,
    input  logic      oe_b_n,
    output logic      drive
);

    logic enables_on;
    logic load_sel;

    always_comb begin
        enables_on = !oe_a_n && !oe_b_n;
        load_sel   = (mode == MODE_LOAD);
        drive      = enables_on && !load_sel;
    end

    // The load mode must release the pins even with both enables active.
    assert_load_releases_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |-> !drive);

    // Either inactive enable releases the pins.
    assert_enable_releases_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !drive);

endmodule

// File: rtl/usr_core.sv
module usr_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  usr_mode_e        mode,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [WIDTH-1:0] up_src;
    logic [WIDTH-1:0] down_src;

    // Neighbour selection per stage; end stages take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign up_src[i] = ser_lo;
        end else begin : g_mid_up
            assign up_src[i] = st_q.stages[i-1];
        end
        if (i == TOP) begin : g_last
            assign down_src[i] = ser_hi;
        end else begin : g_mid_down
            assign down_src[i] = st_q.stages[i+1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.stages = '0;
        end else begin
            unique case (mode)
                MODE_KEEP: st_d.stages = st_q.stages;
                MODE_UP:   st_d.stages = up_src;
                MODE_DOWN: st_d.stages = down_src;
                MODE_LOAD: st_d.stages = par_in;
                default:   st_d.stages = st_q.stages;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stages = st_q.stages;

    assert_keep_stable_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_KEEP) |=> $stable(stages));

    assert_shift_up_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_UP) |=>
            (stages[0] == $past(ser_lo)) && (stages[TOP:1] == $past(stages[TOP-1:0])));

    assert_shift_down_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_DOWN) |=>
            (stages[TOP] == $past(ser_hi)) && (stages[TOP-1:0] == $past(stages[TOP:1])));

    assert_load_capture_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_LOAD) |=> (stages == $past(par_in)));

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_b1,
    input  logic             sel_b0,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic             pad_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int TOP = WIDTH - 1;

    usr_mode_e        mode;
    logic [WIDTH-1:0] stages;

    assign mode = usr_mode_e'({sel_b1, sel_b0});

    usr_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .ser_lo (ser_in_lo),
        .ser_hi (ser_in_hi),
        .par_in (pad_in),
        .stages (stages)
    );

    usr_port_ctrl u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .drive  (pad_oe)
    );

    assign pad_out = stages;
    assign tap_lo  = stages[0];
    assign tap_hi  = stages[TOP];

    // Synchronous clear observed one edge after reset is sampled low.
    always @(posedge clk) begin
        if ($past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0) begin
            assert_clear_R1 : assert (pad_out == '0);
        end
    end

endmodule

// File: tb/univ_shift_reg_bench.sv
module univ_shift_reg_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_b1 = 1'b0, sel_b0 = 1'b0;
    logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic         ser_in_lo = 1'b0, ser_in_hi = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic         pad_oe, tap_lo, tap_hi;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [W-1:0] model = '0;
    string        state_tag = "R1";

    univ_shift_reg #(.WIDTH(W)) u_univ_shift_reg (
        .clk(clk), .rst_n(rst_n), .sel_b1(sel_b1), .sel_b0(sel_b0),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_in_lo(ser_in_lo),
        .ser_in_hi(ser_in_hi), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit rst, input logic [1:0] md, input bit ea, input bit eb,
                        input bit slo, input bit shi, input logic [W-1:0] pin);
        logic exp_oe;
        string oe_tag;
        @(negedge clk);
        rst_n = !rst; {sel_b1, sel_b0} = md; oe_a_n = ea; oe_b_n = eb;
        ser_in_lo = slo; ser_in_hi = shi; pad_in = pin;
        #1;
        exp_oe = !ea && !eb && (md != 2'b11);
        if (md == 2'b11)  oe_tag = "R6";
        else if (ea | eb) oe_tag = "R7";
        else              oe_tag = "R8";
        chk(oe_tag, {{(W-1){1'b0}}, pad_oe}, {{(W-1){1'b0}}, exp_oe});
        // Stage value reached through the port word; enables were random (R10).
        chk(state_tag, pad_out, model);
        chk("R9", {{(W-2){1'b0}}, tap_hi, tap_lo}, {{(W-2){1'b0}}, model[W-1], model[0]});
        @(posedge clk);
        if (rst) begin
            model = '0; state_tag = "R1";
        end else begin
            case (md)
                2'b00: begin state_tag = "R2"; end
                2'b01: begin model = (model << 1) | W'(slo); state_tag = "R3"; end
                2'b10: begin model = (model >> 1) | (W'(shi) << (W-1)); state_tag = "R4"; end
                default: begin model = pin; state_tag = "R5"; end
            endcase
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pats [6];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h3C};
        // Reset state, including reset held in load mode with enables active (R1, R6)
        step(1, 2'b11, 0, 0, 1, 1, 8'hFF);
        step(1, 2'b11, 0, 0, 1, 1, 8'hFF);
        step(1, 2'b00, 0, 0, 0, 0, 8'h00);
        // Reset must override a load (R1)
        step(0, 2'b11, 1, 1, 0, 0, 8'hC3);
        step(1, 2'b11, 0, 0, 0, 0, 8'h7E);
        // Walk a lone bit up and down with enables off (R3, R4, R10)
        step(0, 2'b11, 1, 0, 0, 0, 8'h01);
        for (int k = 0; k < W; k++) step(0, 2'b01, 1, 1, 0, 0, 8'h00);
        step(0, 2'b10, 0, 1, 1, 0, 8'h00);
        for (int k = 0; k < W; k++) step(0, 2'b10, 1, 1, 0, 0, 8'h00);
        // Sweep all mode/enable/serial combinations over data words
        for (int p = 0; p < 6; p++) begin
            for (int r = 0; r < 3; r++) begin
                for (int md = 0; md < 4; md++)
                    for (int e = 0; e < 4; e++)
                        for (int s = 0; s < 4; s++)
                            step(0, md[1:0], e[1], e[0], s[0], s[1], pats[p] ^ W'(r * 37 + md * 5 + s));
                step((r == 1), 2'b11, 0, 0, 1, 0, pats[p]);
            end
        end
        step(0, 2'b00, 0, 0, 0, 0, 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule